// File: doc/BRIEF.md
# Reciprocal Counter Gate Controller

This block runs the gating half of a reciprocal frequency counter. A start command opens a gate whose length is given in reference clock cycles. Opening the gate does not begin the measurement. It only arms the start, and the measurement begins on the next rising edge of the measured input. When the gate length has elapsed, the stop is armed, and the measurement ends on the next rising edge of the input after that.

Between the start edge and the stop edge the block counts two things: input rising edges and reference clocks. It reports both counts. Downstream logic divides events by actual elapsed time to get frequency, or the inverse to get period. The requested gate is only a guide, because the span actually measured runs edge to edge. It is normally a little longer than the request.

The input must already be synchronized to the reference clock. Its rising edges must be at least four reference clocks apart. If no input edge arrives within a timeout after either arming point, the block raises a one-cycle no-signal error and goes back to idle.

Top module: `recip_gate_ctrl`

## Requirements
- R1: After synchronous reset, `res_valid_o`, `nosig_err_o` and `busy_o` are 0, and both count outputs are 0.
- R2: The clock edge that samples `start_i` high in idle is edge 0. A rising edge at edge k means `sig_i` is 1 at edge k and was 0 at edge k-1. The start edge is the first rising edge at an edge index of 1 or more.
- R3: With gate length G, the stop edge is the first rising edge after the start edge whose index is at least G+2. G = 0 is legal.
- R4: `evt_count_o` equals the number of rising edges from the start edge inclusive to the stop edge exclusive.
- R5: `ref_count_o` equals the stop edge index minus the start edge index.
- R6: `res_valid_o` goes high right after the stop edge. It stays high, with both counts unchanged, until `res_ack_i` is sampled high. It is low after that edge.
- R7: The start is armed at edge 0. The stop is armed at edge max(G+1, start+1). If no rising edge arrives within TIMEOUT edges after an arming edge, `nosig_err_o` is high for exactly one cycle, right after edge arm+TIMEOUT. The block then returns to idle, and `res_valid_o` stays 0.
- R8: A high `start_i` while a measurement is running, or while a result is held, has no effect on the result. After the acknowledge the block is idle.
- R9: `busy_o` is 1 from just after the start command until the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start command, acted on in idle |
| gate_len_i | input | GATE_W | Requested gate length in reference clocks |
| sig_i | input | 1 | Synchronized measured signal |
| res_ack_i | input | 1 | Acknowledge of a held result |
| res_valid_o | output | 1 | Result is held and valid |
| evt_count_o | output | CNT_W | Input edges counted over the span |
| ref_count_o | output | CNT_W | Reference clocks counted over the span |
| nosig_err_o | output | 1 | One-cycle no-signal error pulse |
| busy_o | output | 1 | A measurement is in progress or held |

## Verification
The result is due on the reference edge that takes the stop edge, so `res_valid_o` and both counts are read at the falling edge right after it. The bench records the edge index where valid first appears and compares it with the stop index it computed from its own record of the input. A no-signal error is due exactly TIMEOUT edges after its arming edge. It is checked at that half-cycle and again one cycle later, to confirm it was a single-cycle pulse. Hold, ignored-start and acknowledge behaviour are checked one cycle after each stimulus, because every output comes from a single state register.

// File: rtl/rcg_pkg.sv
package rcg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_WAIT_START = 3'd1,
        ST_RUN        = 3'd2,
        ST_WAIT_STOP  = 3'd3,
        ST_DONE       = 3'd4
    } rcg_state_e;

    // control strobes from the sequencer to the datapath
    typedef struct packed {
        logic gate_load;
        logic span_clr;
        logic evt_inc;
        logic ref_inc;
    } rcg_ctl_t;

    function automatic logic in_span(input rcg_state_e st);
        return (st == ST_RUN) || (st == ST_WAIT_STOP);
    endfunction

    function automatic logic in_wait(input rcg_state_e st);
        return (st == ST_WAIT_START) || (st == ST_WAIT_STOP);
    endfunction

endpackage

// File: rtl/rcg_edge_det.sv
module rcg_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    output logic rise_o
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b0;
        else     sig_q <= sig_i;
    end

    assign rise_o = sig_i & ~sig_q;

endmodule

// File: rtl/rcg_gate_timer.sv
module rcg_gate_timer #(
    parameter int GATE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [GATE_W-1:0] len_i,
    output logic              expired_o
);
    logic [GATE_W-1:0] cnt_q;
    logic              exp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else if (load_i) begin
            cnt_q <= len_i;
            exp_q <= (len_i == '0);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == GATE_W'(1)) exp_q <= 1'b1;
        end
    end

    assign expired_o = exp_q;

    // once the gate has run out, the stop stays armed until the next load
    p_gate_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (exp_q && !load_i) |=> exp_q);

endmodule

// File: rtl/rcg_span_ctr.sv
module rcg_span_ctr #(
    parameter int          CNT_W    = 24,
    parameter logic [31:0] LOAD_VAL = 32'd0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] LoadV = CNT_W'(LOAD_VAL);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (clr_i) cnt_q <= LoadV;
        else if (inc_i) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/rcg_fsm.sv
module rcg_fsm
    import rcg_pkg::*;
#(
    parameter int TIMEOUT = 1024
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     rise_i,
    input  logic     gate_exp_i,
    input  logic     ack_i,
    output rcg_ctl_t ctl_o,
    output logic     res_valid_o,
    output logic     nosig_err_o,
    output logic     busy_o
);
    localparam int TO_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [TO_W-1:0] ToLast = TO_W'(TIMEOUT - 1);

    rcg_state_e      st_q, st_n;
    logic [TO_W-1:0] wait_q;
    logic            wait_clr, wait_inc, err_n, err_q;
    rcg_ctl_t        ctl;

    always_comb begin
        st_n     = st_q;
        ctl      = '0;
        wait_clr = 1'b0;
        wait_inc = 1'b0;
        err_n    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    st_n          = ST_WAIT_START;
                    ctl.gate_load = 1'b1;
                    wait_clr      = 1'b1;
                end
            end
            ST_WAIT_START: begin
                if (rise_i) begin
                    st_n         = ST_RUN;
                    ctl.span_clr = 1'b1;
                end else if (wait_q == ToLast) begin
                    st_n  = ST_IDLE;
                    err_n = 1'b1;
                end else begin
                    wait_inc = 1'b1;
                end
            end
            ST_RUN: begin
                ctl.ref_inc = 1'b1;
                ctl.evt_inc = rise_i;
                if (gate_exp_i) begin
                    st_n     = ST_WAIT_STOP;
                    wait_clr = 1'b1;
                end
            end
            ST_WAIT_STOP: begin
                ctl.ref_inc = 1'b1;
                if (rise_i) begin
                    st_n = ST_DONE;
                end else if (wait_q == ToLast) begin
                    st_n  = ST_IDLE;
                    err_n = 1'b1;
                end else begin
                    wait_inc = 1'b1;
                end
            end
            ST_DONE: begin
                if (ack_i) st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            wait_q <= '0;
            err_q  <= 1'b0;
        end else begin
            st_q  <= st_n;
            err_q <= err_n;
            if (wait_clr)      wait_q <= '0;
            else if (wait_inc) wait_q <= wait_q + 1'b1;
        end
    end

    assign ctl_o       = ctl;
    assign res_valid_o = (st_q == ST_DONE);
    assign nosig_err_o = err_q;
    assign busy_o      = (st_q != ST_IDLE);

    // error is a single-cycle pulse
    p_err_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        nosig_err_o |=> !nosig_err_o);

    // the timeout counter never runs past its limit while waiting
    p_wait_bound_r7: assert property (@(posedge clk) disable iff (rst)
        in_wait(st_q) |-> (wait_q <= ToLast));

    // after an error the block is idle
    p_err_idle_r7: assert property (@(posedge clk) disable iff (rst)
        nosig_err_o |-> !busy_o);

    // counting happens only inside the measured span
    p_span_only_r5: assert property (@(posedge clk) disable iff (rst)
        ctl.ref_inc |-> in_span(st_q));

endmodule

// File: rtl/recip_gate_ctrl.sv
module recip_gate_ctrl
    import rcg_pkg::*;
#(
    parameter int GATE_W  = 16,
    parameter int CNT_W   = 24,
    parameter int TIMEOUT = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [GATE_W-1:0] gate_len_i,
    input  logic              sig_i,
    input  logic              res_ack_i,
    output logic              res_valid_o,
    output logic [CNT_W-1:0]  evt_count_o,
    output logic [CNT_W-1:0]  ref_count_o,
    output logic              nosig_err_o,
    output logic              busy_o
);
    logic     rise, gate_exp;
    rcg_ctl_t ctl;

    rcg_edge_det u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_i  (sig_i),
        .rise_o (rise)
    );

    rcg_gate_timer #(.GATE_W(GATE_W)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .load_i    (ctl.gate_load),
        .len_i     (gate_len_i),
        .expired_o (gate_exp)
    );

    // the start edge itself is the first counted event; time starts at zero
    rcg_span_ctr #(.CNT_W(CNT_W), .LOAD_VAL(32'd1)) u_evt (
        .clk   (clk),
        .rst   (rst),
        .clr_i (ctl.span_clr),
        .inc_i (ctl.evt_inc),
        .cnt_o (evt_count_o)
    );

    rcg_span_ctr #(.CNT_W(CNT_W), .LOAD_VAL(32'd0)) u_ref (
        .clk   (clk),
        .rst   (rst),
        .clr_i (ctl.span_clr),
        .inc_i (ctl.ref_inc),
        .cnt_o (ref_count_o)
    );

    rcg_fsm #(.TIMEOUT(TIMEOUT)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .rise_i      (rise),
        .gate_exp_i  (gate_exp),
        .ack_i       (res_ack_i),
        .ctl_o       (ctl),
        .res_valid_o (res_valid_o),
        .nosig_err_o (nosig_err_o),
        .busy_o      (busy_o)
    );

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && !res_ack_i) |=>
            (res_valid_o && $stable(evt_count_o) && $stable(ref_count_o)));

    p_ref_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(res_valid_o) |-> (ref_count_o != '0));

    p_evt_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(res_valid_o) |-> (evt_count_o != '0));

    p_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(res_valid_o && nosig_err_o));

endmodule

// File: tb/tb_recip_gate_ctrl.sv
`timescale 1ns/1ps
module tb_recip_gate_ctrl;
    localparam int GATE_W = 16;
    localparam int CNT_W  = 24;
    localparam int TO     = 40;
    localparam int MAXC   = 600;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [GATE_W-1:0] gate_len_i = '0;
    logic sig_i = 1'b0;
    logic res_ack_i = 1'b0;
    logic res_valid_o, nosig_err_o, busy_o;
    logic [CNT_W-1:0] evt_count_o, ref_count_o;

    always #2.5 clk = ~clk;

    recip_gate_ctrl #(.GATE_W(GATE_W), .CNT_W(CNT_W), .TIMEOUT(TO)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .gate_len_i(gate_len_i),
        .sig_i(sig_i), .res_ack_i(res_ack_i), .res_valid_o(res_valid_o),
        .evt_count_o(evt_count_o), .ref_count_o(ref_count_o),
        .nosig_err_o(nosig_err_o), .busy_o(busy_o)
    );

    int  nchk = 0;
    int  nfail = 0;
    bit  finished = 0;
    bit  sigh [0:MAXC];
    int  nlen;
    int  vat, errat;
    bit  errseen;

    typedef struct packed {
        logic [15:0] gate;
        logic [7:0]  step;
        logic [7:0]  phase;
        logic [7:0]  poke;
    } vec_t;

    // gate length, phase step per clock (of 256), start phase, cycle of a stray start
    localparam vec_t VECS [0:6] = '{
        '{16'd20, 8'd37, 8'd0,   8'd0},
        '{16'd20, 8'd64, 8'd100, 8'd0},
        '{16'd0,  8'd50, 8'd200, 8'd0},
        '{16'd57, 8'd23, 8'd30,  8'd6},
        '{16'd33, 8'd41, 8'd129, 8'd0},
        '{16'd1,  8'd60, 8'd250, 8'd3},
        '{16'd90, 8'd55, 8'd77,  8'd0}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit rise_at(input int k);
        return sigh[k+1] && !sigh[k];
    endfunction

    // drive a measurement; edge 0 is the edge sampling start_i
    task automatic run_meas(input int g, input int step, input int phase,
                            input int poke, input int max_edges);
        int acc = phase;
        int nedge = 0;
        bit s;
        @(negedge clk);
        gate_len_i = GATE_W'(g);
        start_i = 1'b1;
        acc += step;
        s = acc[7];
        if (s && !sig_i) nedge++;
        sigh[0] = sig_i;
        sig_i = s;
        sigh[1] = s;
        vat = -1; errseen = 0; errat = -1; nlen = 1;
        for (int k = 1; k < MAXC - 1; k++) begin
            @(negedge clk);
            if (k == 1) chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
            if (res_valid_o) begin vat = k - 1; break; end
            if (nosig_err_o) begin errseen = 1; errat = k - 1; break; end
            start_i = (poke != 0 && k == poke);
            acc += step;
            s = acc[7];
            if (s && !sig_i) begin
                if (nedge >= max_edges) s = 1'b0;
                else nedge++;
            end
            sig_i = s;
            sigh[k+1] = s;
            nlen = k + 1;
        end
        start_i = 1'b0;
    endtask

    task automatic quiet(input int n);
        @(negedge clk);
        sig_i = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic meas_vector(input vec_t v);
        int g, st, sp, ev;
        logic [CNT_W-1:0] he, hr;
        g = int'(v.gate);
        run_meas(g, int'(v.step), int'(v.phase), int'(v.poke), 1000);
        st = -1; sp = -1; ev = 0;
        for (int k = 1; k < nlen; k++) begin
            if (st < 0) begin
                if (rise_at(k)) st = k;
            end else if (sp < 0) begin
                if (rise_at(k) && k >= g + 2) sp = k;
                else if (rise_at(k)) ev++;
            end
        end
        ev++;
        chk(!errseen, "R2 no error expected", errseen, 0);
        chk(vat == sp, "R3 stop edge / valid timing", vat, sp);
        chk(int'(ref_count_o) == sp - st, "R2 R5 reference count", ref_count_o, sp - st);
        chk(int'(evt_count_o) == ev, v.poke != 0 ? "R4 R8 event count with stray start" : "R4 event count",
            evt_count_o, ev);
        he = evt_count_o; hr = ref_count_o;
        sig_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(res_valid_o && evt_count_o == he && ref_count_o == hr, "R6 result held",
            res_valid_o, 1);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(res_valid_o && ref_count_o == hr, "R8 start ignored while holding", res_valid_o, 1);
        res_ack_i = 1'b1;
        @(negedge clk);
        res_ack_i = 1'b0;
        chk(!res_valid_o, "R6 valid clears on ack", res_valid_o, 0);
        chk(!busy_o, "R8 idle after ack", busy_o, 0);
        quiet(3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!res_valid_o && !nosig_err_o && !busy_o, "R1 reset flags", {res_valid_o, nosig_err_o, busy_o}, 0);
        chk(evt_count_o == '0 && ref_count_o == '0, "R1 reset counts", evt_count_o + ref_count_o, 0);

        foreach (VECS[i]) meas_vector(VECS[i]);

        // no edge at all after arming the start
        run_meas(15, 0, 0, 0, 1000);
        chk(errseen && errat == TO, "R7 start timeout edge", errat, TO);
        @(negedge clk);
        chk(!nosig_err_o, "R7 error is one cycle", nosig_err_o, 0);
        chk(!busy_o && !res_valid_o, "R7 idle without result", {busy_o, res_valid_o}, 0);
        quiet(3);

        // one edge starts the span, then the input dies
        begin
            int st, exp_at;
            run_meas(10, 60, 0, 0, 1);
            st = -1;
            for (int k = 1; k < nlen; k++) if (st < 0 && rise_at(k)) st = k;
            exp_at = ((11 > st + 1) ? 11 : st + 1) + TO;
            chk(errseen && errat == exp_at, "R7 stop timeout edge", errat, exp_at);
            @(negedge clk);
            chk(!nosig_err_o && !busy_o && !res_valid_o, "R7 stop timeout returns idle",
                {nosig_err_o, busy_o, res_valid_o}, 0);
            quiet(3);
        end

        // a normal measurement still works after an error
        meas_vector('{16'd12, 8'd45, 8'd5, 8'd0});

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule